// File: doc/BRIEF.md
# Quasi-Bidirectional I/O Port with Latch Readback

This block is one general-purpose I/O port with a configurable number of pins. Each pin has an output latch bit. A cleared latch bit pulls its pin strongly low. A set latch bit turns the pull-down off, so something outside sets the level. In the default variant a weak pull-up holds the pin high when nothing else drives it. A pin becomes usable as an input only after a 1 has been written to its latch bit.

The register side takes one operation code per cycle, with write data and a bit index. It accepts full-byte writes, single-bit set, clear and complement, and logical and arithmetic read-modify-write updates. It has two read paths. A plain pin read returns the pin levels, seen through a two-flop synchronizer. Every read-modify-write operation, and an explicit latch read, uses the latch value and never the pin value. The result appears on the read-data output one clock after the operation.

The block has a second variant, chosen by a parameter. In this open-drain variant there is no internal pull-up. The variant can also lend the pins to an external memory cycle. During that cycle the port drives the low address byte while the address strobe is high, and carries data while the strobe is low.

Top module: `qbd_port`

## Requirements
- R1: After reset every latch bit is 1, bus_rdata is 0 and no pin is strongly driven (pad_oe = 0); in the default variant pad_pullup is all ones.
- R2: Outside an external memory cycle, a latch bit of 0 sets its pad_oe bit with pad_level 0, and a latch bit of 1 clears its pad_oe bit; in the default variant pad_pullup equals the latch.
- R3: Op code 1 (byte write) replaces every latch bit with bus_wdata, and the pads follow from the next clock edge.
- R4: Op codes 9, 10 and 11 (bit set, clear, complement) change only the latch bit selected by bus_bit.
- R5: Op code 2 (pin read) loads bus_rdata with pin_in delayed by two register stages, so a read that samples at the first or second edge after a pin change returns the old level and a read that samples at the third edge returns the new level. The latch is unchanged.
- R6: Op code 3 (latch read), and every read-modify-write op (4 to 11), load bus_rdata with the latch value held before the operation, whatever the pins show.
- R7: Op codes 4, 5 and 6 set the latch to latch AND, OR and XOR bus_wdata.
- R8: Op codes 7 and 8 add or subtract one from the latch modulo 2^WIDTH (0xFF+1 = 0x00, 0x00-1 = 0xFF).
- R9: A read-modify-write uses the latch, not the pins, even when the pins differ from the latch or change in the same cycle.
- R10: In the open-drain variant pad_pullup is always 0.
- R11: In the open-drain variant, while ext_en is 1 the pads are strongly driven with ext_addr when ext_ale is 1, and with ext_data under ext_data_oe when ext_ale is 0. The latch is not altered, and the pads follow it again once ext_en falls.
- R12: In the default variant ext_en, ext_ale, ext_addr, ext_data and ext_data_oe have no effect on the pads.
- R13: Op codes 0 and 12 to 15 leave the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_op | input | 4 | Operation code for this cycle |
| bus_wdata | input | 8 | Write or operand data |
| bus_bit | input | 3 | Bit index for single-bit ops |
| bus_rdata | output | 8 | Read result, registered |
| pin_in | input | 8 | Sensed pin levels |
| ext_en | input | 1 | External memory cycle in progress |
| ext_ale | input | 1 | Address phase strobe |
| ext_addr | input | 8 | Low address byte to drive |
| ext_data | input | 8 | Data byte to drive |
| ext_data_oe | input | 8 | Per-pin drive enable in the data phase |
| pad_oe | output | 8 | Strong drive enable per pin |
| pad_level | output | 8 | Level driven when pad_oe is set |
| pad_pullup | output | 8 | Weak pull-up enable per pin |

## Verification
The bench places pin changes on exact edges relative to a pin read. A synchronizer with the wrong depth would return the new level one read too early or too late. It also makes the pins disagree with the latch, and changes them in the same cycle as a logical update. A design that fed the pins into the update path would then write back the pin levels. The bit operations run on neighbouring bits, and the increment and decrement cross the wrap-around. This exposes a bad mask or an increment that does not wrap. The external memory cycle runs on both variants at once, so a mux that leaks into the default variant, or that overwrites the latch, shows up on the pads.

// File: rtl/qbd_pkg.sv
package qbd_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_IDLE    = 4'd0;
    localparam logic [OP_W-1:0] OP_WR_BYTE = 4'd1;
    localparam logic [OP_W-1:0] OP_RD_PIN  = 4'd2;
    localparam logic [OP_W-1:0] OP_RD_LAT  = 4'd3;
    localparam logic [OP_W-1:0] OP_AND     = 4'd4;
    localparam logic [OP_W-1:0] OP_OR      = 4'd5;
    localparam logic [OP_W-1:0] OP_XOR     = 4'd6;
    localparam logic [OP_W-1:0] OP_INC     = 4'd7;
    localparam logic [OP_W-1:0] OP_DEC     = 4'd8;
    localparam logic [OP_W-1:0] OP_BSET    = 4'd9;
    localparam logic [OP_W-1:0] OP_BCLR    = 4'd10;
    localparam logic [OP_W-1:0] OP_BCPL    = 4'd11;

    function automatic logic is_bit_op(input logic [OP_W-1:0] op);
        return (op == OP_BSET) || (op == OP_BCLR) || (op == OP_BCPL);
    endfunction

endpackage

// File: rtl/qbd_sync.sv
module qbd_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d;
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_comb begin
        stage_d[0] = din;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_chain
            always_comb begin
                stage_d[s] = stage_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/qbd_alu.sv
module qbd_alu
    import qbd_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int BIT_W = 3
) (
    input  logic [OP_W-1:0]  op,
    input  logic [WIDTH-1:0] latch_val,
    input  logic [WIDTH-1:0] wdata,
    input  logic [BIT_W-1:0] bit_sel,
    output logic [WIDTH-1:0] latch_nxt,
    output logic             reads_pin,
    output logic             reads_latch
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] sel_mask;

    always_comb begin
        sel_mask    = ONE << bit_sel;
        latch_nxt   = latch_val;
        reads_pin   = 1'b0;
        reads_latch = 1'b0;
        case (op)
            OP_WR_BYTE: latch_nxt = wdata;
            OP_RD_PIN:  reads_pin = 1'b1;
            OP_RD_LAT:  reads_latch = 1'b1;
            OP_AND: begin
                latch_nxt   = latch_val & wdata;
                reads_latch = 1'b1;
            end
            OP_OR: begin
                latch_nxt   = latch_val | wdata;
                reads_latch = 1'b1;
            end
            OP_XOR: begin
                latch_nxt   = latch_val ^ wdata;
                reads_latch = 1'b1;
            end
            OP_INC: begin
                latch_nxt   = latch_val + ONE;
                reads_latch = 1'b1;
            end
            OP_DEC: begin
                latch_nxt   = latch_val - ONE;
                reads_latch = 1'b1;
            end
            OP_BSET: begin
                latch_nxt   = latch_val | sel_mask;
                reads_latch = 1'b1;
            end
            OP_BCLR: begin
                latch_nxt   = latch_val & ~sel_mask;
                reads_latch = 1'b1;
            end
            OP_BCPL: begin
                latch_nxt   = latch_val ^ sel_mask;
                reads_latch = 1'b1;
            end
            default: latch_nxt = latch_val;
        endcase
    end

endmodule

// File: rtl/qbd_pad_drive.sv
module qbd_pad_drive #(
    parameter int WIDTH      = 8,
    parameter bit OPEN_DRAIN = 1'b0
) (
    input  logic [WIDTH-1:0] latch_val,
    input  logic             mux_on,
    input  logic             ale,
    input  logic [WIDTH-1:0] addr,
    input  logic [WIDTH-1:0] data,
    input  logic [WIDTH-1:0] data_oe,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_level,
    output logic [WIDTH-1:0] pad_pullup
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            if (OPEN_DRAIN) begin : g_od
                always_comb begin
                    pad_pullup[i] = 1'b0;
                    if (mux_on) begin
                        pad_oe[i]    = ale ? 1'b1 : data_oe[i];
                        pad_level[i] = ale ? addr[i] : data[i];
                    end else begin
                        pad_oe[i]    = ~latch_val[i];
                        pad_level[i] = 1'b0;
                    end
                end
            end else begin : g_qb
                logic unused_mux;
                assign unused_mux = mux_on ^ ale ^ addr[i] ^ data[i] ^ data_oe[i];
                always_comb begin
                    pad_oe[i]     = ~latch_val[i];
                    pad_level[i]  = 1'b0;
                    pad_pullup[i] = latch_val[i];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/qbd_port.sv
module qbd_port
    import qbd_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit OPEN_DRAIN  = 1'b0,
    localparam int BIT_W      = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  bus_op,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic [BIT_W-1:0] bus_bit,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    input  logic             ext_en,
    input  logic             ext_ale,
    input  logic [WIDTH-1:0] ext_addr,
    input  logic [WIDTH-1:0] ext_data,
    input  logic [WIDTH-1:0] ext_data_oe,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_level,
    output logic [WIDTH-1:0] pad_pullup
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] rdata;
    } port_state_t;

    port_state_t      st_d;
    port_state_t      st_q;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] latch_nxt;
    logic             reads_pin;
    logic             reads_latch;
    logic             mux_on;
    logic [WIDTH-1:0] sel_mask;

    assign mux_on   = OPEN_DRAIN && ext_en;
    assign sel_mask = ONE << bus_bit;

    qbd_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_sync)
    );

    qbd_alu #(
        .WIDTH (WIDTH),
        .BIT_W (BIT_W)
    ) u_alu (
        .op          (bus_op),
        .latch_val   (st_q.latch),
        .wdata       (bus_wdata),
        .bit_sel     (bus_bit),
        .latch_nxt   (latch_nxt),
        .reads_pin   (reads_pin),
        .reads_latch (reads_latch)
    );

    always_comb begin
        st_d       = st_q;
        st_d.latch = latch_nxt;
        if (reads_pin) begin
            st_d.rdata = pin_sync;
        end else if (reads_latch) begin
            st_d.rdata = st_q.latch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch <= '1;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

    qbd_pad_drive #(
        .WIDTH      (WIDTH),
        .OPEN_DRAIN (OPEN_DRAIN)
    ) u_drive (
        .latch_val  (st_q.latch),
        .mux_on     (mux_on),
        .ale        (ext_ale),
        .addr       (ext_addr),
        .data       (ext_data),
        .data_oe    (ext_data_oe),
        .pad_oe     (pad_oe),
        .pad_level  (pad_level),
        .pad_pullup (pad_pullup)
    );

    AST_CLEARED_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_on |-> (((pad_oe & pad_level) == '0) && ((pad_oe | st_q.latch) == '1))); // R2

    AST_BIT_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        is_bit_op(bus_op) |=> (((st_q.latch ^ $past(st_q.latch)) & ~$past(sel_mask)) == '0)); // R4

    AST_PIN_READ_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op == OP_RD_PIN) |=> $stable(st_q.latch)); // R5

    AST_RMW_RETURNS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        reads_latch |=> (bus_rdata == $past(st_q.latch))); // R6

    AST_UNKNOWN_OP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_op == OP_IDLE) || (bus_op > OP_BCPL)) |=> $stable(st_q.latch)); // R13

    AST_ADDR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_on && ext_ale) |-> ((pad_oe == '1) && (pad_level == ext_addr))); // R11

    AST_OD_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        mux_on |-> (pad_pullup == '0)); // R10

endmodule

// File: tb/qbd_port_bench.sv
module qbd_port_bench;
    import qbd_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_op = OP_IDLE;
    logic [7:0] bus_wdata = 8'h00;
    logic [2:0] bus_bit = 3'd0;
    logic [7:0] pin_in = 8'hFF;
    logic       ext_en = 1'b0;
    logic       ext_ale = 1'b0;
    logic [7:0] ext_addr = 8'h00;
    logic [7:0] ext_data = 8'h00;
    logic [7:0] ext_data_oe = 8'h00;

    logic [7:0] qb_rdata, qb_oe, qb_level, qb_pu;
    logic [7:0] od_rdata, od_oe, od_level, od_pu;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    qbd_port u_qbd_port (
        .clk(clk), .rst_n(rst_n), .bus_op(bus_op), .bus_wdata(bus_wdata),
        .bus_bit(bus_bit), .bus_rdata(qb_rdata), .pin_in(pin_in),
        .ext_en(ext_en), .ext_ale(ext_ale), .ext_addr(ext_addr),
        .ext_data(ext_data), .ext_data_oe(ext_data_oe),
        .pad_oe(qb_oe), .pad_level(qb_level), .pad_pullup(qb_pu)
    );

    qbd_port #(.OPEN_DRAIN(1'b1)) u_qbd_port_od (
        .clk(clk), .rst_n(rst_n), .bus_op(bus_op), .bus_wdata(bus_wdata),
        .bus_bit(bus_bit), .bus_rdata(od_rdata), .pin_in(pin_in),
        .ext_en(ext_en), .ext_ale(ext_ale), .ext_addr(ext_addr),
        .ext_data(ext_data), .ext_data_oe(ext_data_oe),
        .pad_oe(od_oe), .pad_level(od_level), .pad_pullup(od_pu)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // issue one op at a falling edge; results are settled at the next falling edge
    task automatic do_op(input logic [3:0] op, input logic [7:0] d, input logic [2:0] b);
        bus_op = op;
        bus_wdata = d;
        bus_bit = b;
        @(negedge clk);
        bus_op = OP_IDLE;
    endtask

    task automatic read_latch(input string tag, input logic [7:0] exp);
        do_op(OP_RD_LAT, 8'h00, 3'd0);
        chk(tag, qb_rdata, exp);
    endtask

    task automatic t_reset;
        chk("R1 rdata after reset", qb_rdata, 8'h00);
        chk("R1 oe after reset", qb_oe, 8'h00);
        chk("R1 pullup after reset", qb_pu, 8'hFF);
        chk("R10 od pullup after reset", od_pu, 8'h00);
        read_latch("R1 latch after reset", 8'hFF);
    endtask

    task automatic t_write;
        do_op(OP_WR_BYTE, 8'hA5, 3'd0);
        chk("R3 oe after byte write", qb_oe, 8'h5A);
        chk("R2 level low where driven", qb_level & qb_oe, 8'h00);
        chk("R2 pullup follows latch", qb_pu, 8'hA5);
        chk("R10 od pullup off", od_pu, 8'h00);
        read_latch("R3 latch after byte write", 8'hA5);
    endtask

    task automatic t_bits;
        do_op(OP_BSET, 8'h00, 3'd1);
        read_latch("R4 bit set 1", 8'hA7);
        do_op(OP_BCLR, 8'hFF, 3'd7);
        read_latch("R4 bit clear 7", 8'h27);
        do_op(OP_BCPL, 8'h00, 3'd0);
        chk("R4 bit complement rdata old latch", qb_rdata, 8'h27);
        chk("R4 pads after complement", qb_oe, 8'hD9);
        read_latch("R4 bit complement 0", 8'h26);
    endtask

    task automatic t_pin_sync;
        do_op(OP_WR_BYTE, 8'hFF, 3'd0);
        pin_in = 8'h3C;
        do_op(OP_RD_PIN, 8'h00, 3'd0);
        chk("R5 read at first edge old", qb_rdata, 8'hFF);
        do_op(OP_RD_PIN, 8'h00, 3'd0);
        chk("R5 read at second edge old", qb_rdata, 8'hFF);
        do_op(OP_RD_PIN, 8'h00, 3'd0);
        chk("R5 read at third edge new", qb_rdata, 8'h3C);
        read_latch("R5 latch kept after pin reads", 8'hFF);
    endtask

    task automatic t_latch_vs_pin;
        do_op(OP_RD_PIN, 8'h00, 3'd0);
        chk("R6 pin read sees pins", qb_rdata, 8'h3C);
        do_op(OP_RD_LAT, 8'h00, 3'd0);
        chk("R6 latch read sees latch", qb_rdata, 8'hFF);
        do_op(OP_AND, 8'hF0, 3'd0);
        chk("R9 and rdata is latch", qb_rdata, 8'hFF);
        read_latch("R9 and uses latch not pins", 8'hF0);
        pin_in = 8'h00;
        do_op(OP_XOR, 8'h0F, 3'd0);
        chk("R9 xor same-cycle pin change rdata", qb_rdata, 8'hF0);
        read_latch("R9 xor same-cycle pin change", 8'hFF);
        do_op(OP_OR, 8'h00, 3'd0);
        read_latch("R9 or with low pins keeps latch", 8'hFF);
        pin_in = 8'hFF;
    endtask

    task automatic t_logic;
        do_op(OP_WR_BYTE, 8'h5A, 3'd0);
        do_op(OP_AND, 8'h0F, 3'd0);
        chk("R7 and rdata", qb_rdata, 8'h5A);
        read_latch("R7 and", 8'h0A);
        do_op(OP_OR, 8'hC0, 3'd0);
        read_latch("R7 or", 8'hCA);
        do_op(OP_XOR, 8'hFF, 3'd0);
        read_latch("R7 xor", 8'h35);
    endtask

    task automatic t_incdec;
        do_op(OP_WR_BYTE, 8'hFF, 3'd0);
        do_op(OP_INC, 8'h00, 3'd0);
        read_latch("R8 increment wraps", 8'h00);
        do_op(OP_DEC, 8'h00, 3'd0);
        read_latch("R8 decrement wraps", 8'hFF);
        do_op(OP_WR_BYTE, 8'h7F, 3'd0);
        do_op(OP_INC, 8'h00, 3'd0);
        read_latch("R8 increment carry", 8'h80);
    endtask

    task automatic t_unused_ops;
        do_op(OP_WR_BYTE, 8'h96, 3'd0);
        for (int c = 12; c < 16; c++) begin
            do_op(4'(c), 8'h00, 3'd0);
        end
        do_op(OP_IDLE, 8'h00, 3'd0);
        read_latch("R13 unused codes leave latch", 8'h96);
        chk("R13 pads unchanged", qb_oe, 8'h69);
    endtask

    task automatic t_mux;
        ext_en = 1'b1;
        ext_ale = 1'b1;
        ext_addr = 8'h3E;
        ext_data = 8'hC3;
        ext_data_oe = 8'hF0;
        #1;
        chk("R11 address phase oe", od_oe, 8'hFF);
        chk("R11 address phase level", od_level, 8'h3E);
        chk("R12 default variant ignores mux oe", qb_oe, 8'h69);
        chk("R12 default variant ignores mux pullup", qb_pu, 8'h96);
        @(negedge clk);
        ext_ale = 1'b0;
        #1;
        chk("R11 data phase oe", od_oe, 8'hF0);
        chk("R11 data phase level", od_level, 8'hC3);
        chk("R10 od pullup during mux", od_pu, 8'h00);
        chk("R12 default variant level", qb_level, 8'h00);
        @(negedge clk);
        ext_en = 1'b0;
        #1;
        chk("R11 latch restored after mux", od_oe, 8'h69);
        @(negedge clk);
        do_op(OP_RD_LAT, 8'h00, 3'd0);
        chk("R11 od latch unaltered", od_rdata, 8'h96);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_bits();
        t_pin_sync();
        t_latch_vs_pin();
        t_logic();
        t_incdec();
        t_unused_ops();
        t_mux();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule